// File: doc/BRIEF.md
# Handshaked Configuration Word Synchronizer

This block carries a multi-bit configuration word from a source clock domain into a destination clock domain that has no phase or frequency relation to it. A typical use is a slow debug or test-access domain writing control settings that a fast system domain has to apply. The destination clock may also be the slower of the two.

The source presents a word together with a one-cycle load strobe. The block latches the word into a holding register and flips a request toggle. The toggle crosses into the destination through a two-flop synchronizer. When the destination sees the toggle change, it copies the holding register into its output register, pulses a valid flag for one destination cycle, and echoes the toggle back as an acknowledge. The acknowledge crosses back through its own synchronizer and clears the source's busy flag.

The data bits are never synchronized individually. The handshake keeps them still from the moment they are latched until the destination has taken them. The block carries one word at a time, and the source has to wait for busy to drop before a new load is taken.

Top module: `cfg_xfer_sync`

## Requirements
- R1: A load strobe sampled on a source clock edge while the busy output is low is accepted: the word on the source data input at that edge is the one that will be delivered.
- R2: The busy output reads 1 from the source cycle after an accepted load until the acknowledge returns, and reads 0 again after delivery.
- R3: A load strobe sampled while busy is 1 is ignored: its word never appears at the destination, and the word in flight is not altered.
- R4: Every accepted word appears on the destination data output exactly once, with the valid output high, in the order the words were accepted.
- R5: The destination valid output is high for exactly one destination clock cycle per delivered word.
- R6: The destination data output keeps its value while the valid output is low.
- R7: While the resets are asserted (synchronous, active high, one per domain, asserted together), busy and valid read 0 and the destination data output reads all zeros.
- R8: R1 to R6 hold when the destination clock is much slower than the source clock, and also when it is much faster.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_load | input | 1 | Strobe offering src_data for transfer |
| src_data | input | WIDTH | Word to transfer |
| src_busy | output | 1 | High while a transfer is in flight; loads are ignored |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_data | output | WIDTH | Last delivered word |
| dst_valid | output | 1 | One-cycle pulse marking a new word on dst_data |

## Verification
A request toggle lost or doubled inside the block shows up at the ports in one of two ways. Either busy stays high forever, so no further load is taken, or a word arrives twice or out of order. The bench's scoreboard catches either case at the next pulse, or at the end-of-phase drain, at the latest. If the holding register were overwritten while busy, the destination would show a word that was never accepted, and the comparison on the very next valid pulse would flag it. A stuck or stretched valid is caught one destination cycle after it rises, and drift of the output register between pulses is caught on the first destination cycle where it changes.

// File: rtl/cxs_pkg.sv
package cxs_pkg;
  // Smallest synchronizer chain the block accepts.
  localparam int unsigned CXS_MIN_STAGES = 2;

  // A toggle-coded event is seen when the current and previous samples differ.
  function automatic logic cxs_tgl_event(input logic now_v, input logic prev_v);
    return now_v ^ prev_v;
  endfunction
endpackage

// File: rtl/cxs_bit_sync.sv
module cxs_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[LAST-1:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain_q[LAST];
endmodule

// File: rtl/cxs_src_port.sv
module cxs_src_port
  import cxs_pkg::*;
#(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] word,
  input  logic             ack_tgl_async,
  output logic             req_tgl,
  output logic [WIDTH-1:0] hold,
  output logic             busy
);
  logic ack_s;
  logic ack_prev_q;
  logic take;

  cxs_bit_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(ack_tgl_async),
    .q_sync (ack_s)
  );

  assign take = load && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_tgl    <= 1'b0;
      hold       <= '0;
      busy       <= 1'b0;
      ack_prev_q <= 1'b0;
    end else begin
      ack_prev_q <= ack_s;
      if (take) begin
        hold    <= word;
        req_tgl <= ~req_tgl;
        busy    <= 1'b1;
      end else if (cxs_tgl_event(ack_s, ack_prev_q)) begin
        busy <= 1'b0;
      end
    end
  end

  AST_REQ_FLIPS_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
    (load && !busy) |=> (req_tgl != $past(req_tgl)));            // R1
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (load && !busy) |=> busy);                                    // R2
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(hold));                                      // R3
  AST_REQ_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(req_tgl));                                   // R3
endmodule

// File: rtl/cxs_dst_port.sv
module cxs_dst_port
  import cxs_pkg::*;
#(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_tgl_async,
  input  logic [WIDTH-1:0] hold_async,
  output logic             ack_tgl,
  output logic [WIDTH-1:0] data,
  output logic             valid
);
  logic req_s;
  logic req_prev_q;
  logic arrive;

  cxs_bit_sync #(.STAGES(STAGES)) u_req_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(req_tgl_async),
    .q_sync (req_s)
  );

  assign arrive = cxs_tgl_event(req_s, req_prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev_q <= 1'b0;
      ack_tgl    <= 1'b0;
      data       <= '0;
      valid      <= 1'b0;
    end else begin
      req_prev_q <= req_s;
      valid      <= 1'b0;
      if (arrive) begin
        data    <= hold_async;
        valid   <= 1'b1;
        ack_tgl <= req_s;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);                                            // R5
  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(data));                                    // R6
  AST_ACK_MATCHES_REQ: assert property (@(posedge clk) disable iff (rst)
    valid |-> (ack_tgl == req_prev_q));                           // R4
endmodule

// File: rtl/cfg_xfer_sync.sv
module cfg_xfer_sync
  import cxs_pkg::*;
#(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst,
  input  logic             src_load,
  input  logic [WIDTH-1:0] src_data,
  output logic             src_busy,
  input  logic             dst_clk,
  input  logic             dst_rst,
  output logic [WIDTH-1:0] dst_data,
  output logic             dst_valid
);
  logic             req_tgl;
  logic             ack_tgl;
  logic [WIDTH-1:0] hold_word;

  initial begin
    if (STAGES < CXS_MIN_STAGES)
      $error("cfg_xfer_sync: STAGES below minimum");
  end

  cxs_src_port #(.WIDTH(WIDTH), .STAGES(STAGES)) u_src (
    .clk          (src_clk),
    .rst          (src_rst),
    .load         (src_load),
    .word         (src_data),
    .ack_tgl_async(ack_tgl),
    .req_tgl      (req_tgl),
    .hold         (hold_word),
    .busy         (src_busy)
  );

  cxs_dst_port #(.WIDTH(WIDTH), .STAGES(STAGES)) u_dst (
    .clk          (dst_clk),
    .rst          (dst_rst),
    .req_tgl_async(req_tgl),
    .hold_async   (hold_word),
    .ack_tgl      (ack_tgl),
    .data         (dst_data),
    .valid        (dst_valid)
  );
endmodule

// File: tb/cfg_xfer_sync_test.sv
`timescale 1ns/100ps
module cfg_xfer_sync_test;
  localparam int W = 16;
  localparam int MAXQ = 256;
  // Each entry: {word to load, word offered while busy (must be ignored)}
  localparam logic [31:0] VEC [0:7] = '{
    32'h0000_DEAD, 32'hFFFF_BEEF, 32'h1234_0BAD, 32'h1234_F00D,
    32'hA5A5_5A5A, 32'h0001_8000, 32'h8000_7FFF, 32'h7E7E_C0DE
  };

  logic         src_clk = 0, dst_clk = 0;
  logic         src_rst = 1, dst_rst = 1;
  logic         src_load = 0;
  logic [W-1:0] src_data = '0;
  logic         src_busy, dst_valid;
  logic [W-1:0] dst_data;
  realtime      dst_half = 20.0;

  int total = 0, bad = 0;
  logic [W-1:0] expq [MAXQ];
  int wr = 0, rd = 0;
  logic prev_valid = 0;
  logic [W-1:0] last_data = '0;
  bit   done = 0;

  cfg_xfer_sync #(.WIDTH(W), .STAGES(2)) uut (
    .src_clk(src_clk), .src_rst(src_rst), .src_load(src_load),
    .src_data(src_data), .src_busy(src_busy),
    .dst_clk(dst_clk), .dst_rst(dst_rst),
    .dst_data(dst_data), .dst_valid(dst_valid)
  );

  always #2.5 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Destination scoreboard: R4 order/exactly-once, R5 pulse width, R6 hold.
  always @(negedge dst_clk) begin
    if (!dst_rst) begin
      if (dst_valid) begin
        if (rd < wr) begin
          chk(dst_data == expq[rd], "R4 word order", dst_data, expq[rd]);
          rd++;
        end else begin
          chk(0, "R3/R4 unexpected word", dst_data, 0);
        end
        if (prev_valid) chk(0, "R5 valid width", 2, 1);
      end else if (dst_data != last_data) begin
        chk(0, "R6 data held", dst_data, last_data);
      end
      prev_valid = dst_valid;
      last_data  = dst_data;
    end
  end

  task automatic send(input logic [W-1:0] word, input logic [W-1:0] poke);
    @(negedge src_clk);
    while (src_busy) @(negedge src_clk);
    src_data = word; src_load = 1;
    expq[wr] = word; wr++;                      // R1 accepted: busy low at edge
    @(negedge src_clk);
    chk(src_busy == 1'b1, "R2 busy after load", src_busy, 1);
    src_data = poke;                            // R3: offered while busy
    @(negedge src_clk);
    src_load = 0;
  endtask

  task automatic drain();
    while (rd < wr || src_busy) @(negedge src_clk);
    repeat (4) @(negedge src_clk);
    chk(src_busy == 1'b0, "R2 busy clears", src_busy, 0);
    chk(rd == wr, "R4 all delivered", rd, wr);
  endtask

  task automatic run_table();
    for (int i = 0; i < 8; i++) send(VEC[i][31:16], VEC[i][15:0]);
    drain();
  endtask

  task automatic stream(input int cycles, input logic [W-1:0] base);
    for (int i = 0; i < cycles; i++) begin
      @(negedge src_clk);
      src_data = base + W'(i); src_load = 1;
      if (!src_busy) begin expq[wr] = base + W'(i); wr++; end   // R1/R3
    end
    @(negedge src_clk);
    src_load = 0;
    drain();
  endtask

  initial begin
    repeat (6) @(negedge dst_clk);
    // R7: reset values
    chk(src_busy == 0, "R7 busy reset", src_busy, 0);
    chk(dst_valid == 0, "R7 valid reset", dst_valid, 0);
    chk(dst_data == '0, "R7 data reset", dst_data, 0);
    @(negedge src_clk); src_rst = 0;
    @(negedge dst_clk); dst_rst = 0;
    // R8: destination slower (40 ns vs 5 ns)
    run_table();
    stream(120, 16'h3000);
    // R8: destination faster (2 ns vs 5 ns)
    dst_half = 1.0;
    repeat (10) @(negedge src_clk);
    run_table();
    stream(60, 16'hC000);
    chk(dst_valid == 0, "R5 valid idle", dst_valid, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge src_clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd, wr);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule